// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of a character display controller. It owns the 8-bit control word. A host write that sets bit 6 starts a fixed-length run. The run first reads every word of an internal character decoder ROM and adds them up modulo 256. It then drives a dot-matrix frame with a checkerboard, followed by the inverse checkerboard. Bit 5 of the control word is read-only and reports whether the sum matched the constant the ROM was built to give.

The run lasts exactly 2^CNT_W clocks, which is 262,144 with the default parameters. While the run is in progress, host writes to the control word are dropped. On the last cycle the block emits a one-cycle wipe strobe. The surrounding logic uses it to fill the character RAM with the space code, clear the flash RAM and set the user-character address register to all ones. At the same moment the control word drops every bit except the result. A test input can corrupt ROM word 0, so the failing path can be exercised.

Top module: `disp_selftest`

## Requirements
- R1: A write while idle whose data has bit 6 = 1 starts a run. `busy` reads 1 from the cycle after that write, and `ctrl_q[6]` reads 1.
- R2: Control-word bit 5 is read-only. It is 0 after reset, and no host write changes it.
- R3: ROM word a is (a*29 + 7) mod 256. The run sums all 2^ROM_AW words modulo 256 and compares the sum with the same sum computed at elaboration. On a match, bit 5 reads 1 after the run.
- R4: If `rom_fault` is held high during a run, word 0 is read with bit 0 inverted, and bit 5 reads 0 after the run.
- R5: `busy` stays high for exactly 2^CNT_W consecutive cycles.
- R6: For run cycle n (n = 0 is the first busy cycle), `dots` shows in the following cycle: all 0 while n < 2^ROM_AW; the checker mask during the next H cycles, where H = (2^CNT_W - 2^ROM_AW)/2; the inverted mask after that. Bit r*COLS+c of the checker mask is 1 when r+c is even. `dots` is 0 while idle and in the cycle after the run ends.
- R7: Host writes during a run leave `ctrl_q` unchanged and do not change the run length.
- R8: In the cycle after the last run cycle, `ctrl_q` equals {2'b00, result, 5'b0}, `wipe_pulse` is 1 for that single cycle, `fill_char` = 8'h20 and `udc_fill` is all ones. At all other times `fill_char` and `udc_fill` are 0.
- R9: A write while idle with bit 6 = 0 stores bits 7 and 4..0 and does not start a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| rom_fault | input | 1 | Test hook that corrupts ROM word 0 |
| ctrl_q | output | 8 | Control word readback |
| busy | output | 1 | Self-test in progress |
| dots | output | ROWS*COLS | Frame drive pattern, bit r*COLS+c |
| wipe_pulse | output | 1 | One-cycle end-of-test wipe strobe |
| fill_char | output | 8 | Character RAM fill code, valid with wipe |
| udc_fill | output | UDC_AW | User-character address fill value, valid with wipe |

## Verification
The start write takes effect at the clock edge that captures it. `busy` and `ctrl_q` show the new value one edge later. Every frame value appears one edge after the count value that selects it, so the bench compares the sample taken after edge k against the phase of count k-1. The result bit, the wipe strobe and the fill values all appear together after edge 2^CNT_W, counted from the start edge. The bench samples one time unit after each rising edge and runs every cycle of a small configuration, so each output is checked in every cycle of every run.

// File: rtl/st_pkg.sv
package st_pkg;

  typedef enum logic [1:0] {
    PH_DARK   = 2'd0,
    PH_CHECK  = 2'd1,
    PH_INVERT = 2'd2
  } phase_t;

  // Decoder ROM contents are computed, not tabulated.
  function automatic logic [7:0] rom_word(input int unsigned a);
    int unsigned v;
    v = a * 29 + 7;
    return v[7:0];
  endfunction

  function automatic logic [7:0] rom_sum(input int unsigned depth);
    logic [7:0] s;
    s = 8'd0;
    for (int unsigned i = 0; i < depth; i++) s = s + rom_word(i);
    return s;
  endfunction

endpackage

// File: rtl/st_rom.sv
module st_rom #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = st_pkg::rom_word(i);
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/st_sum.sv
module st_sum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         vld,
  input  logic [W-1:0] data,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (vld)   sum <= sum + data;
  end

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!vld && !clr) |=> $stable(sum)); // R3
endmodule

// File: rtl/st_pattern.sv
module st_pattern #(
  parameter int ROWS = 7,
  parameter int COLS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  st_pkg::phase_t       phase,
  output logic [ROWS*COLS-1:0] dots
);
  localparam int DOTS = ROWS * COLS;

  logic [DOTS-1:0] mask;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign mask[r*COLS+c] = (((r + c) % 2) == 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dots <= '0;
    else begin
      case (phase)
        st_pkg::PH_CHECK:  dots <= mask;
        st_pkg::PH_INVERT: dots <= ~mask;
        default:           dots <= '0;
      endcase
    end
  end

  AST_DARK_BLANK: assert property (@(posedge clk) disable iff (rst)
    (phase == st_pkg::PH_DARK) |=> (dots == '0)); // R6
  AST_INVERT_COMPL: assert property (@(posedge clk) disable iff (rst)
    (phase == st_pkg::PH_INVERT && $past(phase) == st_pkg::PH_CHECK)
      |=> (dots == ~$past(dots))); // R6
endmodule

// File: rtl/disp_selftest.sv
module disp_selftest #(
  parameter int CNT_W  = 18,
  parameter int ROM_AW = 7,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int UDC_AW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_we,
  input  logic [7:0]           ctrl_wdata,
  input  logic                 rom_fault,
  output logic [7:0]           ctrl_q,
  output logic                 busy,
  output logic [ROWS*COLS-1:0] dots,
  output logic                 wipe_pulse,
  output logic [7:0]           fill_char,
  output logic [UDC_AW-1:0]    udc_fill
);
  import st_pkg::*;

  localparam int unsigned DEPTH   = 1 << ROM_AW;
  localparam int unsigned TOTAL   = 1 << CNT_W;
  localparam int unsigned HALF    = (TOTAL - DEPTH) / 2;
  localparam int unsigned CHK_END = DEPTH + HALF;
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};
  localparam logic [7:0] EXP_SUM = rom_sum(DEPTH);
  localparam logic [7:0] RO_MASK = 8'h20;

  logic [CNT_W-1:0]  cnt;
  logic              start, last, pass;
  logic              rom_en, rd_vld;
  logic [ROM_AW-1:0] addr_d;
  logic [7:0]        rom_q, rom_eff, acc;
  phase_t            phase;

  assign start = !busy && ctrl_we && ctrl_wdata[6];
  assign last  = busy && (cnt == LAST);

  // Run counter and busy flag
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  // ROM sweep and checksum
  assign rom_en = busy && (cnt < CNT_W'(DEPTH));

  st_rom #(.AW(ROM_AW)) u_rom (
    .clk  (clk),
    .en   (rom_en),
    .addr (cnt[ROM_AW-1:0]),
    .q    (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      addr_d <= '0;
    end else begin
      rd_vld <= rom_en;
      addr_d <= cnt[ROM_AW-1:0];
    end
  end

  assign rom_eff = rom_q ^ {7'd0, rom_fault && (addr_d == '0)};

  st_sum #(.W(8)) u_sum (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .vld  (rd_vld),
    .data (rom_eff),
    .sum  (acc)
  );

  assign pass = (acc == EXP_SUM);

  // Display phase selection
  always_comb begin
    phase = PH_DARK;
    if (busy && !last && (cnt >= CNT_W'(DEPTH))) begin
      if (cnt < CNT_W'(CHK_END)) phase = PH_CHECK;
      else                       phase = PH_INVERT;
    end
  end

  st_pattern #(.ROWS(ROWS), .COLS(COLS)) u_pat (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .dots  (dots)
  );

  // Control word and end-of-test effects
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= 8'd0;
      wipe_pulse <= 1'b0;
      fill_char  <= 8'd0;
      udc_fill   <= '0;
    end else begin
      wipe_pulse <= last;
      fill_char  <= last ? 8'h20 : 8'h00;
      udc_fill   <= last ? {UDC_AW{1'b1}} : '0;
      if (last)
        ctrl_q <= {2'b00, pass, 5'b00000};
      else if (!busy && ctrl_we)
        ctrl_q <= (ctrl_wdata & ~RO_MASK) | (ctrl_q & RO_MASK);
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && ctrl_q[6])); // R1
  AST_RO_BIT: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctrl_we) |=> (ctrl_q[5] == $past(ctrl_q[5]))); // R2
  AST_RUN_END: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy); // R5
  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy); // R5
  AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> $stable(ctrl_q)); // R7
  AST_WIPE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wipe_pulse |=> !wipe_pulse); // R8
  AST_WIPE_STATE: assert property (@(posedge clk) disable iff (rst)
    wipe_pulse |-> (ctrl_q[7:6] == 2'b00 && ctrl_q[4:0] == 5'd0 && !busy)); // R8
  AST_IDLE_NOSTART: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctrl_we && !ctrl_wdata[6]) |=> !busy); // R9
endmodule

// File: tb/tb_disp_selftest.sv
module tb_disp_selftest;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 9;
  localparam int ROM_AW = 5;
  localparam int ROWS   = 7;
  localparam int COLS   = 5;
  localparam int UDC_AW = 4;
  localparam int DOTS   = ROWS * COLS;
  localparam int DEPTH  = 1 << ROM_AW;
  localparam int TOTAL  = 1 << CNT_W;
  localparam int HALF   = (TOTAL - DEPTH) / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctrl_we = 1'b0;
  logic [7:0]        ctrl_wdata = 8'd0;
  logic              rom_fault = 1'b0;
  logic [7:0]        ctrl_q;
  logic              busy;
  logic [DOTS-1:0]   dots;
  logic              wipe_pulse;
  logic [7:0]        fill_char;
  logic [UDC_AW-1:0] udc_fill;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  disp_selftest #(.CNT_W(CNT_W), .ROM_AW(ROM_AW), .ROWS(ROWS), .COLS(COLS),
                  .UDC_AW(UDC_AW)) dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .rom_fault(rom_fault), .ctrl_q(ctrl_q), .busy(busy), .dots(dots),
    .wipe_pulse(wipe_pulse), .fill_char(fill_char), .udc_fill(udc_fill)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DOTS-1:0] checker_mask();
    logic [DOTS-1:0] m;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        m[r*COLS+c] = ((r + c) % 2 == 0);
    return m;
  endfunction

  function automatic logic [DOTS-1:0] exp_dots(input int n);
    if (n < DEPTH)             return '0;
    else if (n < DEPTH + HALF) return checker_mask();
    else                       return ~checker_mask();
  endfunction

  function automatic logic [7:0] word_of(input int a, input bit flip);
    logic [7:0] w;
    w = 8'((a * 29 + 7) % 256);
    if (flip && a == 0) w = w ^ 8'h01;
    return w;
  endfunction

  function automatic bit exp_pass(input bit flip);
    logic [7:0] s_ok, s_run;
    s_ok = 8'd0;
    s_run = 8'd0;
    for (int a = 0; a < DEPTH; a++) begin
      s_ok  = s_ok + word_of(a, 1'b0);
      s_run = s_run + word_of(a, flip);
    end
    return s_ok == s_run;
  endfunction

  task automatic idle_write(input logic [7:0] d);
    logic [7:0] prev;
    logic [7:0] expv;
    prev = ctrl_q;
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = d;
    @(posedge clk);
    #1;
    ctrl_we = 1'b0;
    expv = (d & 8'hDF) | (prev & 8'h20);
    chk(ctrl_q == expv, "R9/R2 idle write", ctrl_q, expv);
    chk(busy == 1'b0, "R9 no start", busy, 0);
  endtask

  task automatic run(input logic [7:0] d, input bit flip);
    logic [7:0] run_ctrl;
    logic [7:0] fin;
    run_ctrl = {d[7:6], ctrl_q[5], d[4:0]};
    fin = {2'b00, exp_pass(flip), 5'b0};
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = d;
    rom_fault = flip;
    @(posedge clk);
    #1;
    ctrl_we = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(ctrl_q == run_ctrl, "R1/R2 ctrl at start", ctrl_q, run_ctrl);
    chk(dots == '0, "R6 dark at start", dots, 0);
    for (int k = 1; k <= TOTAL; k++) begin
      @(posedge clk);
      #1;
      // R7: write attempts in the middle of the run
      if (k == 50) begin
        ctrl_we = 1'b1;
        ctrl_wdata = 8'hFF;
      end else if (k == 51) begin
        ctrl_we = 1'b0;
      end
      chk(busy == (k < TOTAL), "R5 busy length", busy, (k < TOTAL));
      if (k < TOTAL) begin
        chk(dots == exp_dots(k - 1), "R6 frame", dots, exp_dots(k - 1));
        chk(ctrl_q == run_ctrl, "R7 ctrl held", ctrl_q, run_ctrl);
        chk(!wipe_pulse && fill_char == 8'd0 && udc_fill == '0,
            "R8 quiet during run", {wipe_pulse, fill_char}, 0);
      end else begin
        chk(dots == '0, "R6 dark after run", dots, 0);
        chk(ctrl_q == fin, flip ? "R4 fail result" : "R3 pass result", ctrl_q, fin);
        chk(wipe_pulse == 1'b1, "R8 wipe strobe", wipe_pulse, 1);
        chk(fill_char == 8'h20, "R8 fill code", fill_char, 8'h20);
        chk(udc_fill == {UDC_AW{1'b1}}, "R8 udc ones", udc_fill, {UDC_AW{1'b1}});
      end
    end
    @(posedge clk);
    #1;
    chk(wipe_pulse == 1'b0, "R8 wipe single", wipe_pulse, 0);
    chk(fill_char == 8'd0, "R8 fill cleared", fill_char, 0);
    chk(busy == 1'b0 && ctrl_q == fin, "R5 stays idle", {busy, ctrl_q}, {1'b0, fin});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(ctrl_q == 8'd0, "R2 reset ctrl", ctrl_q, 0);
    chk(busy == 1'b0 && dots == '0 && !wipe_pulse, "R6 reset idle",
        {busy, wipe_pulse}, 0);
    idle_write(8'h9F);
    idle_write(8'hBF);
    run(8'h40, 1'b0);
    idle_write(8'h3F);
    run(8'hC3, 1'b1);
    run(8'h40, 1'b0);
    rom_fault = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule